// File: doc/BRIEF.md
# Strobe-Timed Host Bus Slave with Ready Handshake

This block lets an asynchronous host with separate active-low read and write strobes reach a byte-wide storage array as if it were plain memory that stretches each cycle through a ready line. The chip select, the strobes and the address are not tied to the internal clock. The block passes the select and the two strobes through a synchronizer. It turns each qualifying strobe edge into exactly one single-cycle internal request on a request/acknowledge port of the array model.

A read is started by the falling edge of the read strobe. A write takes effect on the trailing (rising) edge of the write strobe, when address and data are captured into holding registers. For both kinds of access, an active-low ready output is produced a fixed number of internal clocks after the strobe becomes active. That count depends on the address region and on a normal/early mode input. Ready is withdrawn the moment the host lifts the strobe. The data bus is driven only while a selected read holds the read strobe low.

Top module: `async_host_slave`

## Requirements
- R1: After reset, rdyN is high, no internal request is pending and the data bus is released (reads as the external pull-up value 8'hFF).
- R2: Let k1 be the first rising clock edge after a strobe falls with csN low. rdyN goes low after rising edge number L+2 and not before. In normal mode, L is 4 for the storage region and 5 for the register region.
- R3: rdyN returns high in the same moment the host raises the strobe of the current access, and it is high whenever both strobes are high.
- R4: With earlyMode at 1, L is one less than in normal mode for the same region (3 for storage, 4 for registers).
- R5: An address whose bits [10:8] are all zero lies in the register region; every other address lies in the storage region.
- R6: A selected write stores the byte present on data when the write strobe rises. A later read of the same address returns that byte.
- R7: A write raises the same ready timing as a read, counted from the falling write strobe.
- R8: While rdN is high, the block does not drive the data bus. While a selected read holds rdN low, the bus carries the addressed byte from the moment ready is low.
- R9: A strobe that falls while csN is high is ignored: rdyN stays high, a write does not change the array, and a read does not drive the bus.
- R10: Each accepted strobe edge yields a single-cycle internal request. Once rdyN is low, it stays low until the strobe is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select from the host |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| earlyMode | input | 1 | 1 selects early ready (one clock sooner) |
| addr | input | 11 | Host byte address |
| data | inout | 8 | Bidirectional host data bus |
| rdyN | output | 1 | Active-low ready to the host |

## Verification
The bench builds the block with its default parameters: an 11-bit address, byte data, ready counts of 4 and 5 clocks, and a two-flop synchronizer. With a 3-bit register-region field, both latency regions can be reached within a handful of accesses, including the top storage address 0x7FF. The small counts also put the exact cycle at which ready falls, in all four region/mode combinations, within a short run. The ready line is compared against a behavioural expectation on every clock, so an early, late or sticky ready is caught at its first wrong cycle.

// File: rtl/ahs_pkg.sv
package ahs_pkg;

  // strobes from control to datapath, one cycle wide unless noted
  typedef struct packed {
    logic latchRdAddr;  // capture host address for a read
    logic latchWr;      // capture host address and data for a write
    logic issueRd;      // internal read request
    logic issueWr;      // internal write request
    logic dataOe;       // drive the host data bus (level)
  } ctrlStrobes_t;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } accKind_t;

endpackage

// File: rtl/ahs_mem.sv
module ahs_mem #(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int REG_TOP_BITS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic regHit;
  logic pendReg;

  assign regHit = (addr[ADDR_W-1 -: REG_TOP_BITS] == '0);

  // register-region reads take one extra cycle before acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendReg <= 1'b0;
      ack     <= 1'b0;
    end else begin
      pendReg <= req & ~we & regHit;
      ack     <= (req & ~(~we & regHit)) | pendReg;
    end
  end

  always_ff @(posedge clk) begin
    if (req && we) store[addr] <= wdata;
    rdata <= store[addr];
  end

endmodule

// File: rtl/ahs_dpath.sv
module ahs_dpath
  import ahs_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int REG_TOP_BITS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostDataIn,
  input  ctrlStrobes_t      strobes,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic              regRegion,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] busData
);
  logic [ADDR_W-1:0] addrHold;
  logic [DATA_W-1:0] wdataHold;
  logic [DATA_W-1:0] rdataHold;

  assign regRegion = (hostAddr[ADDR_W-1 -: REG_TOP_BITS] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHold  <= '0;
      wdataHold <= '0;
      rdataHold <= '0;
    end else begin
      if (strobes.latchRdAddr) addrHold <= hostAddr;
      if (strobes.latchWr) begin
        addrHold  <= hostAddr;
        wdataHold <= hostDataIn;
      end
      if (memAck) rdataHold <= memRdata;
    end
  end

  assign memReq   = strobes.issueRd | strobes.issueWr;
  assign memWe    = strobes.issueWr;
  assign memAddr  = addrHold;
  assign memWdata = wdataHold;
  assign busData  = rdataHold;

endmodule

// File: rtl/ahs_ctrl.sv
module ahs_ctrl
  import ahs_pkg::*;
#(
  parameter int RAM_LAT     = 4,
  parameter int REG_LAT     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         rdN,
  input  logic         wrN,
  input  logic         earlyMode,
  input  logic         regRegion,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         rdyN
);
  localparam int CNT_W = $clog2(REG_LAT + 1);
  localparam logic [CNT_W-1:0] RAM_LOAD = CNT_W'(RAM_LAT - 1);
  localparam logic [CNT_W-1:0] REG_LOAD = CNT_W'(REG_LAT - 1);

  // index 0 = read, 1 = write, 2 = select
  logic [SYNC_STAGES-1:0][2:0] syncQ;
  logic prevRd, prevWr;
  logic rdS, wrS, csS;
  logic rdFall, wrFall, rdRise, wrRise;
  logic [CNT_W-1:0] cnt, loadVal;
  logic rdyHold;
  logic issueRdQ, issueWrQ;
  accKind_t kind;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= '1;
      prevRd <= 1'b1;
      prevWr <= 1'b1;
    end else begin
      syncQ[0] <= {csN, wrN, rdN};
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevRd <= syncQ[SYNC_STAGES-1][0];
      prevWr <= syncQ[SYNC_STAGES-1][1];
    end
  end

  assign rdS = syncQ[SYNC_STAGES-1][0];
  assign wrS = syncQ[SYNC_STAGES-1][1];
  assign csS = syncQ[SYNC_STAGES-1][2];

  assign rdFall = prevRd & ~rdS & ~csS & ~busy;
  assign wrFall = prevWr & ~wrS & ~csS & ~busy & ~rdFall;
  assign rdRise = busy & (kind == ACC_READ)  & ~prevRd & rdS;
  assign wrRise = busy & (kind == ACC_WRITE) & ~prevWr & wrS;

  assign loadVal = (regRegion ? REG_LOAD : RAM_LOAD) - CNT_W'(earlyMode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      kind     <= ACC_READ;
      cnt      <= '0;
      rdyHold  <= 1'b0;
      issueRdQ <= 1'b0;
      issueWrQ <= 1'b0;
    end else begin
      issueRdQ <= rdFall;
      issueWrQ <= wrRise;
      if (rdFall || wrFall) begin
        busy    <= 1'b1;
        kind    <= rdFall ? ACC_READ : ACC_WRITE;
        cnt     <= loadVal;
        rdyHold <= 1'b0;
      end else if (rdRise || wrRise) begin
        busy    <= 1'b0;
        cnt     <= '0;
        rdyHold <= 1'b0;
      end else if (busy && cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) rdyHold <= 1'b1;
      end
    end
  end

  always_comb begin
    strobes.latchRdAddr = rdFall;
    strobes.latchWr     = wrRise;
    strobes.issueRd     = issueRdQ;
    strobes.issueWr     = issueWrQ;
    strobes.dataOe      = ~rdN & busy & (kind == ACC_READ);
  end

  // withdrawn at once when the host lifts the strobe
  assign rdyN = ~(rdyHold & ((kind == ACC_WRITE) ? ~wrN : ~rdN));

endmodule

// File: rtl/async_host_slave.sv
module async_host_slave
  import ahs_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int REG_TOP_BITS = 3,
  parameter int RAM_LAT      = 4,
  parameter int REG_LAT      = 5,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              earlyMode,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [DATA_W-1:0] data,
  output logic              rdyN
);
  ctrlStrobes_t      strobes;
  logic              busy;
  logic              regRegion;
  logic              memReq, memWe, memAck;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata, memRdata, busData;
  logic              dataOe;

  ahs_ctrl #(
    .RAM_LAT(RAM_LAT), .REG_LAT(REG_LAT), .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .earlyMode(earlyMode), .regRegion(regRegion),
    .strobes(strobes), .busy(busy), .rdyN(rdyN)
  );

  ahs_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_TOP_BITS(REG_TOP_BITS)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .hostAddr(addr), .hostDataIn(data),
    .strobes(strobes), .memAck(memAck), .memRdata(memRdata),
    .regRegion(regRegion), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .busData(busData)
  );

  ahs_mem #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_TOP_BITS(REG_TOP_BITS)
  ) mem_i (
    .clk(clk), .rstN(rstN), .req(memReq), .we(memWe), .addr(memAddr),
    .wdata(memWdata), .ack(memAck), .rdata(memRdata)
  );

  assign dataOe = strobes.dataOe;
  assign data   = dataOe ? busData : 'z;

endmodule

// File: rtl/ahs_checker.sv
module ahs_checker
  import ahs_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         rdN,
  input logic         wrN,
  input logic         rdyN,
  input logic         busy,
  input logic         dataOe,
  input ctrlStrobes_t strobes,
  input logic         memReq,
  input logic         memAck
);
  // R3: no ready while both strobes are idle
  a_r3_idle_no_ready: assert property (@(posedge clk) disable iff (!rstN)
    (rdN && wrN) |-> rdyN);

  // R8: bus never driven with the read strobe high
  a_r8_bus_released: assert property (@(posedge clk) disable iff (!rstN)
    rdN |-> !dataOe);

  // R10: internal requests are single-cycle pulses
  a_r10_rd_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issueRd |=> !strobes.issueRd);
  a_r10_wr_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issueWr |=> !strobes.issueWr);

  // R9: ready only inside an accepted access
  a_r9_ready_needs_access: assert property (@(posedge clk) disable iff (!rstN)
    !rdyN |-> busy);

  // R6: array acknowledges only requests it was given
  a_r6_ack_after_req: assert property (@(posedge clk) disable iff (!rstN)
    memAck |-> ($past(memReq) || $past(memReq, 2)));
endmodule

bind async_host_slave ahs_checker chk_i (
  .clk(clk), .rstN(rstN), .rdN(rdN), .wrN(wrN), .rdyN(rdyN), .busy(busy),
  .dataOe(dataOe), .strobes(strobes), .memReq(memReq), .memAck(memAck)
);

// File: tb/async_host_slave_tb_top.sv
`timescale 1ns/1ps
module async_host_slave_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rdN = 1'b1, wrN = 1'b1, earlyR = 1'b0;
  logic [10:0] addrR = '0;
  logic tbDrive = 1'b0;
  logic [7:0] tbData = '0;
  wire  [7:0] dataBus;
  logic rdyN;

  int errors = 0;
  int checks = 0;
  bit running = 1'b0;
  bit tracking = 1'b0;
  int edgeCnt = 0;
  int accL = 0;
  string curTag = "R1";
  logic [7:0] refMem [int];

  always #2 clk = ~clk;

  assign dataBus = tbDrive ? tbData : 'z;
  for (genvar i = 0; i < 8; i++) begin : g_pu
    pullup (dataBus[i]);
  end

  async_host_slave dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .earlyMode(earlyR), .addr(addrR), .data(dataBus), .rdyN(rdyN)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference ready timing, compared every clock
  always @(posedge clk) if (tracking) edgeCnt++;

  always @(negedge clk) begin
    if (running) begin
      logic expRdy;
      expRdy = (tracking && edgeCnt >= accL + 2) ? 1'b0 : 1'b1;
      checks++;
      if (rdyN !== expRdy) begin
        errors++;
        $display("FAIL %s rdyN=%b expected %b at edge %0d", curTag, rdyN, expRdy, edgeCnt);
      end
    end
  end

  task automatic access(input bit isWr, input logic [10:0] a, input logic [7:0] wv,
                        input bit early, input bit csOn, input string tag);
    int lat;
    lat = ((a[10:8] == 3'b000) ? 5 : 4) - (early ? 1 : 0);
    @(negedge clk); #1;
    addrR = a; csN = !csOn; earlyR = early;
    if (isWr) begin tbDrive = 1'b1; tbData = wv; end
    @(negedge clk); #1;
    curTag = tag; accL = lat; edgeCnt = 0; tracking = csOn;
    if (isWr) wrN = 1'b0; else rdN = 1'b0;
    repeat (lat + 6) @(negedge clk);
    if (!isWr) check({tag, " R8 read data"}, dataBus, csOn ? refMem[int'(a)] : 8'hFF);
    #1;
    if (isWr) wrN = 1'b1; else rdN = 1'b1;
    tracking = 1'b0;
    #1;
    check({tag, " R3 ready dropped on release"}, {7'd0, rdyN}, 8'd1);
    if (!isWr) check({tag, " R8 bus released"}, dataBus, 8'hFF);
    if (isWr && csOn) refMem[int'(a)] = wv;
    repeat (6) @(negedge clk);
    #1; tbDrive = 1'b0; csN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 ready idle", {7'd0, rdyN}, 8'd1);
    check("R1 bus released", dataBus, 8'hFF);
    running = 1'b1;

    access(1'b1, 11'h345, 8'hA5, 1'b0, 1'b1, "R6 R7 storage write");
    access(1'b0, 11'h345, 8'h00, 1'b0, 1'b1, "R2 R10 storage read");
    access(1'b1, 11'h012, 8'h3C, 1'b1, 1'b1, "R4 R5 R7 register write");
    access(1'b0, 11'h012, 8'h00, 1'b0, 1'b1, "R5 R2 register read");
    access(1'b0, 11'h012, 8'h00, 1'b1, 1'b1, "R4 R5 register early read");
    access(1'b0, 11'h345, 8'h00, 1'b1, 1'b1, "R4 storage early read");
    access(1'b1, 11'h345, 8'h77, 1'b0, 1'b0, "R9 unselected write");
    access(1'b0, 11'h345, 8'h00, 1'b0, 1'b1, "R9 R6 readback unchanged");
    access(1'b0, 11'h345, 8'h00, 1'b0, 1'b0, "R9 unselected read");
    access(1'b1, 11'h7FF, 8'h5A, 1'b1, 1'b1, "R6 R5 top address write");
    access(1'b0, 11'h7FF, 8'h00, 1'b0, 1'b1, "R6 R10 top address read");
    access(1'b1, 11'h100, 8'hC3, 1'b0, 1'b1, "R5 region boundary write");
    access(1'b0, 11'h100, 8'h00, 1'b0, 1'b1, "R5 region boundary read");
    access(1'b0, 11'h0FF, 8'h00, 1'b0, 1'b0, "R9 unselected register read");

    running = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule